// File: doc/BRIEF.md
# Replicated-Register Steering Target Lookup

This block maps a register address to the steering target that unicast accesses to that register must use. Each address lies in one of several replication classes. Every class owns a small table of inclusive address windows and one stored group/instance pair. A configuration port fills the window tables, and it also loads each class's target and a flag that marks the target as valid.

A lookup request carries one address. The block then walks the tables one entry per cycle, in ascending class order, and stops at the first window that contains the address. The highest-numbered class is special. It holds addresses whose steering is already fixed in hardware. It is searched only after every other class has missed, and a hit there reports that no steering is needed. An address that falls in no window gets the safe default target 0/0 and a miss warning.

Top module: `steer_lookup`

## Requirements
- R1: A window matches an address when start <= address <= end; both bounds are inclusive.
- R2: Within a class, the search stops at the first entry whose end value is zero. Entries placed after that terminator are never matched.
- R3: Classes are searched from index 0 upward, and the first matching window wins. An address covered by two classes resolves to the lower index.
- R4: A hit in an ordinary class (index below NUM_CLASS-1) returns rsp_steer=1 together with that class's stored group and instance.
- R5: The implicit class (index NUM_CLASS-1) is searched only after all other classes have missed. A hit there returns rsp_steer=0, group 0, instance 0, and no warnings.
- R6: An address that matches no window returns rsp_steer=1, group 0, instance 0 and rsp_miss=1.
- R7: A class whose first entry has end zero has no windows. It is skipped and its target is never returned.
- R8: A hit in an ordinary class whose valid flag is clear still returns that class's target, with rsp_uninit=1.
- R9: The scan examines exactly one table entry per clock. A hit on the k-th entry examined raises done for a single cycle, k clocks after the edge that accepted the request.
- R10: A request presented while busy is high is ignored. It changes neither the result nor the number of done pulses.
- R11: After reset, busy and done are low and every table is empty, so any lookup ends as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_range_we | input | 1 | Write one window entry |
| cfg_class | input | CW | Class addressed by a configuration write |
| cfg_idx | input | RW | Entry position within the class |
| cfg_start | input | AW | Window start address |
| cfg_end | input | AW | Window end address; zero marks end of list |
| cfg_tgt_we | input | 1 | Write the class target and valid flag |
| cfg_group | input | GW | Group target |
| cfg_inst | input | IW | Instance target |
| cfg_valid | input | 1 | Target-valid flag |
| req_valid | input | 1 | Lookup request |
| req_addr | input | AW | Address to look up |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_steer | output | 1 | Steering needed |
| rsp_group | output | GW | Result group |
| rsp_inst | output | IW | Result instance |
| rsp_miss | output | 1 | No window matched |
| rsp_uninit | output | 1 | Matched class target not marked valid |

## Verification
The assertions assume that the tables and targets are not rewritten while a scan is running. They also assume that every window has start no greater than end. The bench loads its whole configuration before the first lookup and issues configuration writes only while busy is low. Every window it programs is ordered. The only overlaps it creates are deliberate ones that probe class priority. Requests sent during a scan are applied on purpose, to exercise the busy rule.

// File: rtl/steer_lookup.sv
module steer_lookup #(
  parameter int NUM_CLASS = 10,
  parameter int NUM_RANGE = 12,
  parameter int AW = 24,
  parameter int GW = 8,
  parameter int IW = 8,
  localparam int CW = $clog2(NUM_CLASS),
  localparam int RW = $clog2(NUM_RANGE),
  localparam int NENT = NUM_CLASS * NUM_RANGE,
  localparam int EW = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_range_we,
  input  logic [CW-1:0] cfg_class,
  input  logic [RW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic          cfg_tgt_we,
  input  logic [GW-1:0] cfg_group,
  input  logic [IW-1:0] cfg_inst,
  input  logic          cfg_valid,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done,
  output logic          rsp_steer,
  output logic [GW-1:0] rsp_group,
  output logic [IW-1:0] rsp_inst,
  output logic          rsp_miss,
  output logic          rsp_uninit
);
  localparam int IMPL = NUM_CLASS - 1;

  logic [AW-1:0] win_lo [NENT];
  logic [AW-1:0] win_hi [NENT];
  logic [GW-1:0] tgt_grp [NUM_CLASS];
  logic [IW-1:0] tgt_ins [NUM_CLASS];
  logic          tgt_ok  [NUM_CLASS];

  logic [CW-1:0] cls_q;
  logic [RW-1:0] idx_q;
  logic [AW-1:0] addr_q;
  logic          busy_q, done_q;

  logic [EW-1:0] ent, wr_ent;
  logic [AW-1:0] cur_lo, cur_hi;
  logic          term, hit, last_ent, last_cls, cls_end;

  assign ent      = EW'(int'(cls_q) * NUM_RANGE + int'(idx_q));
  assign wr_ent   = EW'(int'(cfg_class) * NUM_RANGE + int'(cfg_idx));
  assign cur_lo   = win_lo[ent];
  assign cur_hi   = win_hi[ent];
  assign term     = (cur_hi == '0);
  assign hit      = !term && (cur_lo <= addr_q) && (addr_q <= cur_hi);
  assign last_ent = (idx_q == RW'(NUM_RANGE - 1));
  assign last_cls = (cls_q == CW'(IMPL));
  assign cls_end  = term || (last_ent && !hit);

  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        win_lo[e] <= '0;
        win_hi[e] <= '0;
      end
      for (int c = 0; c < NUM_CLASS; c++) begin
        tgt_grp[c] <= '0;
        tgt_ins[c] <= '0;
        tgt_ok[c]  <= 1'b0;
      end
    end else begin
      if (cfg_range_we && int'(cfg_class) < NUM_CLASS && int'(cfg_idx) < NUM_RANGE) begin
        win_lo[wr_ent] <= cfg_start;
        win_hi[wr_ent] <= cfg_end;
      end
      if (cfg_tgt_we && int'(cfg_class) < NUM_CLASS) begin
        tgt_grp[cfg_class] <= cfg_group;
        tgt_ins[cfg_class] <= cfg_inst;
        tgt_ok[cfg_class]  <= cfg_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      cls_q      <= '0;
      idx_q      <= '0;
      addr_q     <= '0;
      rsp_steer  <= 1'b0;
      rsp_group  <= '0;
      rsp_inst   <= '0;
      rsp_miss   <= 1'b0;
      rsp_uninit <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          addr_q <= req_addr;
          cls_q  <= '0;
          idx_q  <= '0;
        end
      end else if (hit) begin
        busy_q     <= 1'b0;
        done_q     <= 1'b1;
        rsp_miss   <= 1'b0;
        rsp_steer  <= !last_cls;
        rsp_group  <= last_cls ? '0 : tgt_grp[cls_q];
        rsp_inst   <= last_cls ? '0 : tgt_ins[cls_q];
        rsp_uninit <= !last_cls && !tgt_ok[cls_q];
      end else if (cls_end) begin
        if (last_cls) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          rsp_steer  <= 1'b1;
          rsp_group  <= '0;
          rsp_inst   <= '0;
          rsp_miss   <= 1'b1;
          rsp_uninit <= 1'b0;
        end else begin
          cls_q <= cls_q + 1'b1;
          idx_q <= '0;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_from_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));

  p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(addr_q));

  p_nosteer_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !rsp_steer) |-> (rsp_group == '0 && rsp_inst == '0 && !rsp_miss && !rsp_uninit));

  p_miss_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && rsp_miss) |-> (rsp_steer && rsp_group == '0 && rsp_inst == '0 && !rsp_uninit));
endmodule

// File: tb/tb_steer_lookup.sv
module tb_steer_lookup;
  localparam int AW = 24, GW = 8, IW = 8, CW = 4, RW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_range_we = 0, cfg_tgt_we = 0, cfg_valid = 0, req_valid = 0;
  logic [CW-1:0] cfg_class = 0;
  logic [RW-1:0] cfg_idx = 0;
  logic [AW-1:0] cfg_start = 0, cfg_end = 0, req_addr = 0;
  logic [GW-1:0] cfg_group = 0;
  logic [IW-1:0] cfg_inst = 0;
  logic busy, done, rsp_steer, rsp_miss, rsp_uninit;
  logic [GW-1:0] rsp_group;
  logic [IW-1:0] rsp_inst;

  int checks = 0, fails = 0;

  steer_lookup dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_range_we(cfg_range_we), .cfg_class(cfg_class), .cfg_idx(cfg_idx),
    .cfg_start(cfg_start), .cfg_end(cfg_end),
    .cfg_tgt_we(cfg_tgt_we), .cfg_group(cfg_group), .cfg_inst(cfg_inst), .cfg_valid(cfg_valid),
    .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .done(done), .rsp_steer(rsp_steer), .rsp_group(rsp_group),
    .rsp_inst(rsp_inst), .rsp_miss(rsp_miss), .rsp_uninit(rsp_uninit)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [AW-1:0] a;
    logic          s;
    logic [GW-1:0] g;
    logic [IW-1:0] i;
    logic          m;
    logic          u;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{24'h00B100, 1'b1, 8'd3,  8'd1, 1'b0, 1'b0},
    '{24'h00B3FF, 1'b1, 8'd3,  8'd1, 1'b0, 1'b0},
    '{24'h00B400, 1'b1, 8'd0,  8'd0, 1'b1, 1'b0},
    '{24'h00B0FF, 1'b1, 8'd5,  8'd2, 1'b0, 1'b0},
    '{24'h008C80, 1'b1, 8'd5,  8'd2, 1'b0, 1'b0},
    '{24'h004000, 1'b1, 8'd9,  8'd4, 1'b0, 1'b1},
    '{24'h0048FF, 1'b1, 8'd9,  8'd4, 1'b0, 1'b1},
    '{24'h004900, 1'b0, 8'd0,  8'd0, 1'b0, 1'b0},
    '{24'h001800, 1'b0, 8'd0,  8'd0, 1'b0, 1'b0},
    '{24'h020800, 1'b1, 8'd0,  8'd0, 1'b1, 1'b0},
    '{24'h030B05, 1'b1, 8'h11, 8'd6, 1'b0, 1'b0},
    '{24'h030B10, 1'b1, 8'd0,  8'd0, 1'b1, 1'b0},
    '{24'h000000, 1'b1, 8'd0,  8'd0, 1'b1, 1'b0}
  };
  string vtag [NV] = '{"R1", "R1", "R6", "R3", "R4", "R8", "R7", "R5", "R5", "R2", "R4", "R6", "R6"};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic set_range(input int c, input int k, input int lo, input int hi);
    @(negedge clk);
    cfg_range_we = 1; cfg_class = CW'(c); cfg_idx = RW'(k);
    cfg_start = AW'(lo); cfg_end = AW'(hi);
    @(negedge clk);
    cfg_range_we = 0;
  endtask

  task automatic set_tgt(input int c, input int g, input int i, input logic ok);
    @(negedge clk);
    cfg_tgt_we = 1; cfg_class = CW'(c); cfg_group = GW'(g); cfg_inst = IW'(i); cfg_valid = ok;
    @(negedge clk);
    cfg_tgt_we = 0;
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, output int lat);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(posedge clk);
    #1 req_valid = 0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      #1;
    end while (!done && lat < 200);
  endtask

  task automatic chk_rsp(input string tag, input vec_t v);
    chk(tag, "done", int'(done), 1);
    chk(tag, "steer", int'(rsp_steer), int'(v.s));
    chk(tag, "group", int'(rsp_group), int'(v.g));
    chk(tag, "inst", int'(rsp_inst), int'(v.i));
    chk(tag, "miss", int'(rsp_miss), int'(v.m));
    chk(tag, "uninit", int'(rsp_uninit), int'(v.u));
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int pulses;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    chk("R11", "busy after reset", int'(busy), 0);
    chk("R11", "done after reset", int'(done), 0);
    // R11: empty tables: all ten classes skipped, one cycle each
    do_lookup(24'h00B100, lat);
    chk_rsp("R11", '{24'h00B100, 1'b1, 8'd0, 8'd0, 1'b1, 1'b0});
    chk("R11", "empty scan cycles", lat, 10);

    set_range(0, 0, 'h00B100, 'h00B3FF);
    set_tgt(0, 3, 1, 1);
    set_range(1, 0, 'h008C80, 'h008CFF);
    set_range(1, 1, 'h00B000, 'h00B3FF);
    set_tgt(1, 5, 2, 1);
    set_tgt(2, 7, 7, 1);
    set_range(3, 0, 'h004000, 'h0048FF);
    set_range(3, 2, 'h020000, 'h020FFF);
    set_tgt(3, 9, 4, 0);
    for (int k = 0; k < 12; k++) set_range(4, k, 'h030000 + k * 'h100, 'h03000F + k * 'h100);
    set_tgt(4, 'h11, 6, 1);
    set_range(9, 0, 'h001000, 'h001FFF);
    set_range(9, 1, 'h004000, 'h004AFF);
    set_tgt(9, 'h55, 'h66, 1);

    for (int v = 0; v < NV; v++) begin
      do_lookup(VECS[v].a, lat);
      chk_rsp(vtag[v], VECS[v]);
    end

    // R9: one entry per clock
    do_lookup(24'h00B100, lat);
    chk("R9", "latency class0 entry0", lat, 1);
    do_lookup(24'h008C80, lat);
    chk("R9", "latency class1 entry0", lat, 3);
    @(posedge clk); #1;
    chk("R9", "done one cycle", int'(done), 0);

    // R10: second request during scan is ignored
    @(negedge clk);
    req_valid = 1; req_addr = 24'h008C80;
    @(posedge clk);
    #1 req_addr = 24'h004900;
    @(posedge clk);
    @(posedge clk);
    #1 req_valid = 0;
    @(posedge clk); #1;
    chk_rsp("R10", '{24'h008C80, 1'b1, 8'd5, 8'd2, 1'b0, 1'b0});
    pulses = 0;
    for (int n = 0; n < 30; n++) begin
      @(posedge clk); #1;
      if (done) pulses++;
    end
    chk("R10", "extra done pulses", pulses, 0);
    chk("R10", "busy stays low", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule